// File: doc/BRIEF.md
# Dual-Lane Shift-Mask-Add Interpolator

This block is an arithmetic helper that sits on a simple 32-bit register bus. It holds two accumulators, three base registers and one configuration register per lane. Each lane takes an accumulator (its own or the other lane's), shifts it right, keeps a chosen bit field, can sign-extend that field, and adds a base value. A third result adds the second base to the shift-and-mask outputs of both lanes.

A peek read returns a result and changes nothing. A pop read returns the same value and, on the same clock edge, writes both lane results back into the accumulators. Raw-add bypass, cross-lane input and result routing, and two forced upper bits let software step through tables and address sequences. There is also an add port that adds to an accumulator in one bus write, and a split write that loads two bases at once.

Word addresses (bus_addr): 0 ACC0, 1 ACC1, 2 ADD0, 3 ADD1, 4 BASE0, 5 BASE1, 6 BASE2, 7 SPLIT, 8 CFG0, 9 CFG1, 10 to 12 PEEK lane 0/1/2, 13 to 15 POP lane 0/1/2. Configuration layout: shift [4:0], field low bit [9:5], field high bit [14:10], signed [15], cross input [16], cross result [17], raw add [18], forced bits [20:19].

Top module: `shiftmask_interp`

## Requirements
- R1: A synchronous active-high reset clears every accumulator, base and configuration register, so every readable address returns 0 afterwards.
- R2: The shift-mask value of a lane is (input >> shift) with only bits low..high (inclusive) kept. The lane result is base plus this value.
- R3: When the field low bit is greater than the field high bit, the shift-mask value is 0 and the lane result equals the lane base.
- R4: With signed set (bit 15), all bits above the field high bit of the shift-mask value copy bit [high] of the masked value.
- R5: With cross input set (bit 16), a lane takes the other lane's accumulator as its input.
- R6: With raw add set (bit 18), the lane result is base plus the unshifted, unmasked input.
- R7: The forced bits [20:19] are ORed into bits 29:28 of the lane 0/1 value returned by peek and pop reads. They are not part of the value written back into the accumulators.
- R8: Result 2 is BASE2 plus the shift-mask values of lane 0 and lane 1. Raw add and the forced bits do not affect it.
- R9: A peek read (addresses 10 to 12) changes no register.
- R10: A pop read (addresses 13 to 15) writes to each accumulator the unforced result of its own lane, or of the other lane when cross result (bit 17) is set, on the same edge.
- R11: Configuration reads show bit 23 set when the lane 0 shifted input has a set bit above the lane 0 field high bit. Bit 24 shows the same for lane 1, and bit 25 is the OR of the two.
- R12: A write to ADD0/ADD1 adds wdata[23:0], zero-extended, to that accumulator modulo 2^32. A write to SPLIT loads wdata[15:0] into BASE0 and wdata[31:16] into BASE1, both zero-extended.
- R13: Configuration writes keep only bits 20:0. Bits 31:26 and 22:21 read as 0. Writes to read-only addresses have no effect, and ADD/SPLIT read as 0.
- R14: When read and write strobes are both high, the write is applied and no pop update happens. With no read strobe, bus_rdata is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_rd | input | 1 | Read strobe; data returned combinationally in the same cycle |
| bus_wr | input | 1 | Write strobe, applied on the rising edge |
| bus_addr | input | 4 | Word address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data |

## Verification
The pop and peek properties assume that a read strobe is either alone or deliberately paired with a write. They assume nothing else drives the accumulators in the cycle of a pop without forced bits or cross result. The add and split properties look only at write cycles and do not depend on read strobes. The stimulus keeps read and write strobes apart except for one directed overlap cycle, and that cycle is exempt from the pop property. The bench also compares every returned word against its behavioural model, including in randomised operation sequences.

// File: rtl/interp_pkg.sv
package interp_pkg;
    localparam int XW        = 32;
    localparam int SH_W      = $clog2(XW);
    localparam int CFG_W     = 21;
    localparam int ADD_W     = 24;
    localparam int SPLIT_W   = 16;
    localparam int FORCE_LSB = 28;
    localparam int OVF0_BIT  = 23;
    localparam int OVF1_BIT  = 24;
    localparam int OVFA_BIT  = 25;
    localparam int N_LANE    = 2;
    localparam int N_BASE    = 3;

    typedef enum logic [3:0] {
        A_ACC0  = 4'd0,  A_ACC1  = 4'd1,  A_ADD0  = 4'd2,  A_ADD1  = 4'd3,
        A_BASE0 = 4'd4,  A_BASE1 = 4'd5,  A_BASE2 = 4'd6,  A_SPLIT = 4'd7,
        A_CFG0  = 4'd8,  A_CFG1  = 4'd9,  A_PEEK0 = 4'd10, A_PEEK1 = 4'd11,
        A_PEEK2 = 4'd12, A_POP0  = 4'd13, A_POP1  = 4'd14, A_POP2  = 4'd15
    } addr_t;

    typedef struct packed {
        logic [1:0]      force_msb;
        logic            raw;
        logic            cross_res;
        logic            cross_in;
        logic            sgn;
        logic [SH_W-1:0] hi;
        logic [SH_W-1:0] lo;
        logic [SH_W-1:0] shift;
    } lane_cfg_t;

    typedef struct packed {
        logic [N_LANE-1:0][XW-1:0] acc;
        logic [N_BASE-1:0][XW-1:0] base;
        lane_cfg_t [N_LANE-1:0]    cfg;
    } interp_state_t;
endpackage

// File: rtl/interp_lane.sv
module interp_lane
    import interp_pkg::*;
#(
    parameter int W  = XW,
    parameter int SW = SH_W
) (
    input  logic [W-1:0]  own_acc,
    input  logic [W-1:0]  other_acc,
    input  logic [W-1:0]  base,
    input  logic [SW-1:0] shift,
    input  logic [SW-1:0] lo,
    input  logic [SW-1:0] hi,
    input  logic          sgn,
    input  logic          cross_in,
    input  logic          raw,
    output logic [W-1:0]  smv,
    output logic [W-1:0]  result,
    output logic          ovf
);
    localparam int EW = W + 1;

    logic [W-1:0]  src;
    logic [W-1:0]  shifted;
    logic [EW-1:0] hi_span;
    logic [W-1:0]  keep_hi;
    logic [W-1:0]  keep_lo;
    logic [W-1:0]  masked;
    logic          sign_bit;

    always_comb begin
        src      = cross_in ? other_acc : own_acc;
        shifted  = src >> shift;
        // ones in bits hi..0, computed one bit wider so hi = W-1 gives all ones
        hi_span  = (EW'(1) << (EW'(hi) + EW'(1))) - EW'(1);
        keep_hi  = hi_span[W-1:0];
        keep_lo  = ~((W'(1) << lo) - W'(1));
        masked   = shifted & keep_hi & keep_lo;
        sign_bit = masked[hi];
        smv      = (sgn && sign_bit) ? (masked | ~keep_hi) : masked;
        ovf      = |(shifted & ~keep_hi);
        result   = base + (raw ? src : smv);
    end
endmodule

// File: rtl/interp_readmux.sv
module interp_readmux
    import interp_pkg::*;
(
    input  addr_t                     addr,
    input  logic                      rd,
    input  logic [N_LANE-1:0][XW-1:0] acc,
    input  logic [N_BASE-1:0][XW-1:0] base,
    input  lane_cfg_t [N_LANE-1:0]    cfg,
    input  logic [N_LANE-1:0]         ovf,
    input  logic [N_BASE-1:0][XW-1:0] res_bus,
    output logic [XW-1:0]             rdata
);
    logic [XW-1:0] status_bits;

    always_comb begin
        status_bits           = '0;
        status_bits[OVF0_BIT] = ovf[0];
        status_bits[OVF1_BIT] = ovf[1];
        status_bits[OVFA_BIT] = |ovf;
        rdata = '0;
        if (rd) begin
            unique case (addr)
                A_ACC0:  rdata = acc[0];
                A_ACC1:  rdata = acc[1];
                A_BASE0: rdata = base[0];
                A_BASE1: rdata = base[1];
                A_BASE2: rdata = base[2];
                A_CFG0:  rdata = status_bits | XW'(cfg[0]);
                A_CFG1:  rdata = status_bits | XW'(cfg[1]);
                A_PEEK0, A_POP0: rdata = res_bus[0];
                A_PEEK1, A_POP1: rdata = res_bus[1];
                A_PEEK2, A_POP2: rdata = res_bus[2];
                default: rdata = '0;
            endcase
        end
    end
endmodule

// File: rtl/shiftmask_interp.sv
module shiftmask_interp
    import interp_pkg::*;
#(
    parameter int ADD_BITS   = ADD_W,
    parameter int SPLIT_BITS = SPLIT_W,
    parameter int FORCE_POS  = FORCE_LSB
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          bus_rd,
    input  logic          bus_wr,
    input  logic [3:0]    bus_addr,
    input  logic [XW-1:0] bus_wdata,
    output logic [XW-1:0] bus_rdata
);
    localparam int HI_BITS = XW - SPLIT_BITS;

    interp_state_t st_d, st_q;

    logic [N_LANE-1:0][XW-1:0] smv;
    logic [N_LANE-1:0][XW-1:0] lane_res;
    logic [N_LANE-1:0]         ovf;
    logic [N_BASE-1:0][XW-1:0] res_bus;
    logic [N_LANE-1:0][XW-1:0] wb;
    logic [XW-1:0]             res2;
    logic [XW-1:0]             add_ext;
    addr_t                     addr;
    logic                      is_pop;

    // observation points for the bound checker
    logic [XW-1:0] obs_acc0, obs_acc1, obs_base0, obs_base1;
    lane_cfg_t     obs_cfg0;

    assign addr = addr_t'(bus_addr);

    for (genvar g = 0; g < N_LANE; g++) begin : g_lane
        interp_lane #(.W(XW), .SW(SH_W)) u_lane (
            .own_acc  (st_q.acc[g]),
            .other_acc(st_q.acc[N_LANE-1-g]),
            .base     (st_q.base[g]),
            .shift    (st_q.cfg[g].shift),
            .lo       (st_q.cfg[g].lo),
            .hi       (st_q.cfg[g].hi),
            .sgn      (st_q.cfg[g].sgn),
            .cross_in (st_q.cfg[g].cross_in),
            .raw      (st_q.cfg[g].raw),
            .smv      (smv[g]),
            .result   (lane_res[g]),
            .ovf      (ovf[g])
        );
        assign res_bus[g] = lane_res[g] | (XW'(st_q.cfg[g].force_msb) << FORCE_POS);
        assign wb[g]      = st_q.cfg[g].cross_res ? lane_res[N_LANE-1-g] : lane_res[g];
    end

    assign res2       = st_q.base[2] + smv[0] + smv[1];
    assign res_bus[2] = res2;

    interp_readmux u_rmux (
        .addr   (addr),
        .rd     (bus_rd),
        .acc    (st_q.acc),
        .base   (st_q.base),
        .cfg    (st_q.cfg),
        .ovf    (ovf),
        .res_bus(res_bus),
        .rdata  (bus_rdata)
    );

    always_comb begin
        add_ext = XW'(bus_wdata[ADD_BITS-1:0]);
        is_pop  = (addr == A_POP0) || (addr == A_POP1) || (addr == A_POP2);
        st_d    = st_q;
        if (bus_wr) begin
            unique case (addr)
                A_ACC0:  st_d.acc[0]  = bus_wdata;
                A_ACC1:  st_d.acc[1]  = bus_wdata;
                A_ADD0:  st_d.acc[0]  = st_q.acc[0] + add_ext;
                A_ADD1:  st_d.acc[1]  = st_q.acc[1] + add_ext;
                A_BASE0: st_d.base[0] = bus_wdata;
                A_BASE1: st_d.base[1] = bus_wdata;
                A_BASE2: st_d.base[2] = bus_wdata;
                A_SPLIT: begin
                    st_d.base[0] = {{HI_BITS{1'b0}}, bus_wdata[SPLIT_BITS-1:0]};
                    st_d.base[1] = {{SPLIT_BITS{1'b0}}, bus_wdata[XW-1:SPLIT_BITS]};
                end
                A_CFG0:  st_d.cfg[0] = lane_cfg_t'(bus_wdata[CFG_W-1:0]);
                A_CFG1:  st_d.cfg[1] = lane_cfg_t'(bus_wdata[CFG_W-1:0]);
                default: ;
            endcase
        end else if (bus_rd && is_pop) begin
            st_d.acc[0] = wb[0];
            st_d.acc[1] = wb[1];
        end
    end

    always_ff @(posedge clk) begin
        if (rst) st_q <= '0;
        else     st_q <= st_d;
    end

    assign obs_acc0  = st_q.acc[0];
    assign obs_acc1  = st_q.acc[1];
    assign obs_base0 = st_q.base[0];
    assign obs_base1 = st_q.base[1];
    assign obs_cfg0  = st_q.cfg[0];
endmodule

// File: rtl/interp_checker.sv
module interp_checker
    import interp_pkg::*;
(
    input logic          clk,
    input logic          rst,
    input logic          bus_rd,
    input logic          bus_wr,
    input logic [3:0]    bus_addr,
    input logic [XW-1:0] bus_wdata,
    input logic [XW-1:0] bus_rdata,
    input logic [XW-1:0] acc0,
    input logic [XW-1:0] acc1,
    input logic [XW-1:0] base0,
    input logic [XW-1:0] base1,
    input lane_cfg_t     cfg0
);
    // R1: registers are clear in the cycle after reset was asserted
    a_r1_reset_clear: assert property (@(posedge clk)
        $past(rst) |-> (acc0 == '0 && acc1 == '0 && base0 == '0 && base1 == '0));

    // R9: peeks leave both accumulators untouched
    a_r9_peek_stable: assert property (@(posedge clk) disable iff (rst)
        (bus_rd && !bus_wr && (bus_addr == A_PEEK0 || bus_addr == A_PEEK1 || bus_addr == A_PEEK2))
        |=> ($stable(acc0) && $stable(acc1)));

    // R10: an unforced, uncrossed pop of lane 0 loads the returned word into ACC0
    a_r10_pop_writeback: assert property (@(posedge clk) disable iff (rst)
        (bus_rd && !bus_wr && bus_addr == A_POP0 && !cfg0.cross_res && cfg0.force_msb == 2'b00)
        |=> (acc0 == $past(bus_rdata)));

    // R11: summary overflow bit is the OR of the two lane bits
    a_r11_ovf_summary: assert property (@(posedge clk) disable iff (rst)
        (bus_rd && (bus_addr == A_CFG0 || bus_addr == A_CFG1))
        |-> (bus_rdata[OVFA_BIT] == (bus_rdata[OVF0_BIT] | bus_rdata[OVF1_BIT])));

    // R12: add port adds the low field zero-extended
    a_r12_add_port: assert property (@(posedge clk) disable iff (rst)
        (bus_wr && bus_addr == A_ADD0)
        |=> (acc0 == $past(acc0) + XW'($past(bus_wdata[ADD_W-1:0]))));

    // R12: split write loads both halves together
    a_r12_split_write: assert property (@(posedge clk) disable iff (rst)
        (bus_wr && bus_addr == A_SPLIT)
        |=> (base0 == XW'($past(bus_wdata[SPLIT_W-1:0])) &&
             base1 == XW'($past(bus_wdata[XW-1:SPLIT_W]))));

    // R13: unused configuration bits read as zero
    a_r13_cfg_zero_bits: assert property (@(posedge clk) disable iff (rst)
        (bus_rd && (bus_addr == A_CFG0 || bus_addr == A_CFG1))
        |-> (bus_rdata[31:26] == 6'd0 && bus_rdata[22:21] == 2'd0));

    // R14: no read strobe means a zero data bus
    a_r14_idle_zero: assert property (@(posedge clk) disable iff (rst)
        !bus_rd |-> (bus_rdata == '0));
endmodule

bind shiftmask_interp interp_checker u_chk (
    .clk      (clk),
    .rst      (rst),
    .bus_rd   (bus_rd),
    .bus_wr   (bus_wr),
    .bus_addr (bus_addr),
    .bus_wdata(bus_wdata),
    .bus_rdata(bus_rdata),
    .acc0     (obs_acc0),
    .acc1     (obs_acc1),
    .base0    (obs_base0),
    .base1    (obs_base1),
    .cfg0     (obs_cfg0)
);

// File: tb/shiftmask_interp_tb.sv
module shiftmask_interp_tb;
    localparam int ACC0 = 0, ACC1 = 1, ADD0 = 2, ADD1 = 3, BASE0 = 4, BASE1 = 5,
                   BASE2 = 6, SPLIT = 7, CFG0 = 8, CFG1 = 9, PEEK0 = 10, PEEK1 = 11,
                   PEEK2 = 12, POP0 = 13, POP1 = 14, POP2 = 15;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        bus_rd = 1'b0;
    logic        bus_wr = 1'b0;
    logic [3:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;

    int n_checks = 0;
    int n_fail   = 0;
    bit finished = 0;

    logic [31:0] macc  [2];
    logic [31:0] mbase [3];
    logic [31:0] mcfg  [2];

    always #5 clk = ~clk;

    shiftmask_interp u_dut (
        .clk(clk), .rst(rst), .bus_rd(bus_rd), .bus_wr(bus_wr),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata)
    );

    function automatic logic [31:0] m_src(int ln);
        return mcfg[ln][16] ? macc[1-ln] : macc[ln];
    endfunction

    function automatic logic [31:0] m_smv(int ln);
        logic [31:0] s = m_src(ln);
        int sh = int'(mcfg[ln][4:0]);
        int lo = int'(mcfg[ln][9:5]);
        int hi = int'(mcfg[ln][14:10]);
        logic [31:0] r = '0;
        for (int i = 0; i < 32; i++)
            if (i >= lo && i <= hi && i + sh < 32) r[i] = s[i + sh];
        if (mcfg[ln][15] && lo <= hi && r[hi])
            for (int i = hi + 1; i < 32; i++) r[i] = 1'b1;
        return r;
    endfunction

    function automatic bit m_ovf(int ln);
        logic [31:0] s = m_src(ln);
        int sh = int'(mcfg[ln][4:0]);
        int hi = int'(mcfg[ln][14:10]);
        for (int i = hi + 1; i < 32; i++)
            if (i + sh < 32 && s[i + sh]) return 1'b1;
        return 1'b0;
    endfunction

    function automatic logic [31:0] m_res(int ln);
        if (ln == 2) return mbase[2] + m_smv(0) + m_smv(1);
        return mbase[ln] + (mcfg[ln][18] ? m_src(ln) : m_smv(ln));
    endfunction

    function automatic logic [31:0] m_bus(int ln);
        logic [31:0] r = m_res(ln);
        if (ln < 2) begin
            r[28] = r[28] | mcfg[ln][19];
            r[29] = r[29] | mcfg[ln][20];
        end
        return r;
    endfunction

    function automatic logic [31:0] m_read(int a);
        logic [31:0] c;
        case (a)
            ACC0: return macc[0];
            ACC1: return macc[1];
            BASE0: return mbase[0];
            BASE1: return mbase[1];
            BASE2: return mbase[2];
            CFG0, CFG1: begin
                c = mcfg[a - CFG0];
                c[23] = m_ovf(0);
                c[24] = m_ovf(1);
                c[25] = m_ovf(0) | m_ovf(1);
                return c;
            end
            PEEK0, POP0: return m_bus(0);
            PEEK1, POP1: return m_bus(1);
            PEEK2, POP2: return m_bus(2);
            default: return 32'h0;
        endcase
    endfunction

    task automatic m_step(bit r, bit w, int a, logic [31:0] d);
        logic [31:0] n0, n1;
        if (w) begin
            case (a)
                ACC0: macc[0] = d;
                ACC1: macc[1] = d;
                ADD0: macc[0] = macc[0] + {8'h0, d[23:0]};
                ADD1: macc[1] = macc[1] + {8'h0, d[23:0]};
                BASE0: mbase[0] = d;
                BASE1: mbase[1] = d;
                BASE2: mbase[2] = d;
                SPLIT: begin mbase[0] = {16'h0, d[15:0]}; mbase[1] = {16'h0, d[31:16]}; end
                CFG0: mcfg[0] = d & 32'h001F_FFFF;
                CFG1: mcfg[1] = d & 32'h001F_FFFF;
                default: ;
            endcase
        end else if (r && a >= POP0) begin
            n0 = mcfg[0][17] ? m_res(1) : m_res(0);
            n1 = mcfg[1][17] ? m_res(0) : m_res(1);
            macc[0] = n0;
            macc[1] = n1;
        end
    endtask

    task automatic check(string tag, logic [31:0] got, logic [31:0] exp, int a);
        n_checks++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s addr=%0d actual=%h expected=%h", tag, a, got, exp);
        end
    endtask

    task automatic op(bit r, bit w, int a, logic [31:0] d, string tag);
        @(negedge clk);
        bus_rd    = r;
        bus_wr    = w;
        bus_addr  = 4'(a);
        bus_wdata = d;
        #2;
        check(tag, bus_rdata, r ? m_read(a) : 32'h0, a);
        m_step(r, w, a, d);
        @(posedge clk);
    endtask

    task automatic wr(int a, logic [31:0] d, string tag);
        op(1'b0, 1'b1, a, d, tag);
    endtask

    task automatic rd(int a, string tag);
        op(1'b1, 1'b0, a, 32'h0, tag);
    endtask

    function automatic logic [31:0] cfgw(int sh, int lo, int hi, bit sg, bit ci,
                                         bit cr, bit rw, int fm);
        return 32'(sh) | (32'(lo) << 5) | (32'(hi) << 10) | (32'(sg) << 15) |
               (32'(ci) << 16) | (32'(cr) << 17) | (32'(rw) << 18) | (32'(fm) << 19);
    endfunction

    task automatic finish_run();
        if (!finished) begin
            finished = 1;
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    endtask

    initial begin
        #(10 * 200000);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        for (int i = 0; i < 2; i++) begin macc[i] = '0; mcfg[i] = '0; end
        for (int i = 0; i < 3; i++) mbase[i] = '0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;

        // R1: everything reads zero after reset
        for (int a = 0; a < 13; a++) rd(a, "R1 reset");

        // R2: shift 4, field 9..2
        wr(ACC0, 32'h1234_5678, "R2 setup");
        wr(BASE0, 32'h0000_0100, "R2 setup");
        wr(CFG0, cfgw(4, 2, 9, 0, 0, 0, 0, 0), "R2 setup");
        rd(PEEK0, "R2 shift mask add");
        rd(CFG0, "R11 overflow flags");

        // R3: empty field
        wr(ACC1, 32'hFFFF_FFFF, "R3 setup");
        wr(BASE1, 32'h0000_0042, "R3 setup");
        wr(CFG1, cfgw(0, 10, 3, 1, 0, 0, 0, 0), "R3 setup");
        rd(PEEK1, "R3 empty mask");

        // R4: signed field 7..0
        wr(ACC0, 32'h0000_0080, "R4 setup");
        wr(CFG0, cfgw(0, 0, 7, 1, 0, 0, 0, 0), "R4 setup");
        rd(PEEK0, "R4 sign extend");
        wr(ACC0, 32'h0000_0070, "R4 setup");
        rd(PEEK0, "R4 positive");

        // R5: lane 1 fed from ACC0
        wr(CFG1, cfgw(1, 0, 15, 0, 1, 0, 0, 0), "R5 setup");
        rd(PEEK1, "R5 cross input");

        // R6: raw add
        wr(CFG0, cfgw(8, 0, 3, 0, 0, 0, 1, 0), "R6 setup");
        rd(PEEK0, "R6 raw add");

        // R8: combined result
        wr(BASE2, 32'h0000_1000, "R8 setup");
        rd(PEEK2, "R8 lane 2");

        // R9: peek leaves state alone
        rd(PEEK0, "R9 peek");
        rd(ACC0, "R9 acc0 unchanged");
        rd(ACC1, "R9 acc1 unchanged");

        // R7: forced bits on the bus only
        wr(CFG0, cfgw(0, 0, 31, 0, 0, 0, 0, 3), "R7 setup");
        rd(PEEK0, "R7 forced bits");
        rd(POP0, "R7 pop");
        rd(ACC0, "R7 writeback unforced");

        // R10: pop with cross result, iterating
        wr(CFG0, cfgw(0, 0, 31, 0, 0, 1, 0, 0), "R10 setup");
        wr(CFG1, cfgw(0, 0, 31, 0, 0, 0, 0, 0), "R10 setup");
        wr(BASE0, 32'h0000_0010, "R10 setup");
        wr(BASE1, 32'h0000_0003, "R10 setup");
        for (int k = 0; k < 3; k++) begin
            rd(POP2, "R10 pop");
            rd(ACC0, "R10 acc0");
            rd(ACC1, "R10 acc1");
        end

        // R11: overflow in lane 1
        wr(ACC1, 32'h8000_0000, "R11 setup");
        wr(CFG1, cfgw(0, 0, 30, 0, 0, 0, 0, 0), "R11 setup");
        rd(CFG1, "R11 overflow");
        rd(CFG0, "R11 overflow mirror");

        // R12: add port wraps and ignores upper bits; split write
        wr(ACC0, 32'hFFFF_FFF0, "R12 setup");
        wr(ADD0, 32'hFF00_0020, "R12 add");
        rd(ACC0, "R12 add wrap");
        wr(ADD1, 32'h00FF_FFFF, "R12 add");
        rd(ACC1, "R12 add acc1");
        wr(SPLIT, 32'hABCD_1234, "R12 split");
        rd(BASE0, "R12 split low");
        rd(BASE1, "R12 split high");
        rd(SPLIT, "R13 split reads zero");
        rd(ADD0, "R13 add reads zero");

        // R13: read-only bits and addresses ignore writes
        wr(CFG0, 32'hFFFF_FFFF, "R13 cfg write");
        rd(CFG0, "R13 cfg readback");
        wr(PEEK1, 32'hDEAD_BEEF, "R13 write peek");
        wr(POP0, 32'hDEAD_BEEF, "R13 write pop");
        rd(ACC0, "R13 acc0 after ro write");
        rd(ACC1, "R13 acc1 after ro write");

        // R14: read and write together: write wins, no pop
        op(1'b1, 1'b1, POP1, 32'h1111_2222, "R14 overlap");
        rd(ACC0, "R14 no pop acc0");
        rd(ACC1, "R14 no pop acc1");
        op(1'b0, 1'b0, ACC0, 32'h0, "R14 idle bus");

        // randomised sequences, all compared against the model
        for (int k = 0; k < 400; k++) begin
            int a = int'($urandom_range(0, 15));
            if ($urandom_range(0, 1) == 0) wr(a, $urandom(), "R10 random write");
            else rd(a, "R10 random read");
        end

        @(negedge clk);
        bus_rd = 1'b0;
        bus_wr = 1'b0;
        finish_run();
    end
endmodule